// File: doc/BRIEF.md
# Four-Channel Bit-Serial Thermometer Front End

This block sits on a host register bus and stands in for four bit-serial digital thermometers that share one command line. The host drives a control port with short strobe codes that reset the serial shifter or move an internal clock-low flag. It sends commands one bit per data write, least significant bit first, and the block collects them into an eight-bit command word. Once a read command is complete, each host read of the data port returns one bit from all four thermometers at once. Bit i of the returned nibble comes from sensor i, and every sensor gives the bit at the same position.

Each sensor holds a nine-bit temperature word in half-degree units and an eight-bit configuration word. Both are loaded at reset and shifted out under host control. After the last bit of the selected word has been read, the shifter clears itself, so every read burst starts with a fresh command. A start-convert command clears the shifter at once. Bits written after a complete command go into a separate data word and move the shared bit position forward.

Top module: `quad_thermo_shifter`

## Requirements
- R1: After rst_n is released, the clock-low flag is clear and a data read returns 4'b0000.
- R2: A control write of 8'h01 clears the command word, the command bit count, the data word and the shared bit position. Control code 8'h02 sets the clock-low flag, 8'h04 clears it, and any other control code changes nothing.
- R3: A data write other than 8'h02 is taken as a bit only while the clock-low flag is set. Otherwise it has no effect.
- R4: Command bits fill an 8-bit command word LSB first. A data code of 8'h01 stores a one, and any other accepted code except 8'h02 stores a zero.
- R5: When the eighth command bit arrives, 8'hEE (start convert) clears the shifter, and 8'hAA (read temperature) and 8'hAC (read configuration) arm reads. Any other command arms nothing.
- R6: A data write of 8'h02 sets the shared bit position to zero whatever the clock-low flag holds, and it shifts no bit.
- R7: While a read command is armed, a data read returns in bit i the bit at the current position of sensor i's selected word, and then the position advances. After the ninth temperature bit or the eighth configuration bit, the shifter fully clears.
- R8: At reset every temperature word holds 9'd44, which is 22 degrees in half-degree units, and every configuration word holds 8'h02, the CPU-mode status flag.
- R9: After a complete command, each accepted bit write stores its value into the data word LSB first and advances the shared position. A later read therefore starts further into the selected word.
- R10: A read while no read command is armed returns 4'b0000 and does not move the position.
- R11: When several accesses happen in one cycle, a control reset (8'h01) takes priority over a data write, and a data write takes priority over a data read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_code | input | 8 | Control code: 8'h01 reset, 8'h02 clock low, 8'h04 clock high |
| dat_wr | input | 1 | Data register write strobe |
| dat_code | input | 8 | Data code: 8'h01 one bit, 8'h02 enable read, others zero bit |
| dat_rd | input | 1 | Data register read strobe, which advances the position at the clock edge |
| rd_bits | output | 4 | Read data, one bit per sensor, valid while dat_rd is high |

## Verification
The hardest case to reach is the shared bit position being moved by something other than reads: data bits written after a complete command, or an enable-read code in the middle of a burst. Only the offset of the following reads shows this. The bench builds these cases with directed sequences: it arms a temperature read, writes two data bits or rewinds partway through, and then compares every remaining bit and the auto-clear point with a model of the position. A sweep over all 256 command values checks arming and auto-clear, including the lengths of both readable words.

// File: rtl/quad_thermo_shifter.sv
module quad_thermo_shifter #(
  parameter int N_SENS   = 4,
  parameter int CMD_W    = 8,
  parameter int CFG_LEN  = 8,
  parameter int TEMP_LEN = 9,
  parameter logic [TEMP_LEN-1:0] TEMP_INIT = 44,
  parameter logic [CFG_LEN-1:0]  CFG_INIT  = 8'h02,
  parameter logic [7:0] CTL_RST    = 8'h01,
  parameter logic [7:0] CTL_CLK_LO = 8'h02,
  parameter logic [7:0] CTL_CLK_HI = 8'h04,
  parameter logic [7:0] DAT_ONE    = 8'h01,
  parameter logic [7:0] DAT_EN_RD  = 8'h02,
  parameter logic [CMD_W-1:0] CMD_CONV    = 8'hEE,
  parameter logic [CMD_W-1:0] CMD_RD_CFG  = 8'hAC,
  parameter logic [CMD_W-1:0] CMD_RD_TEMP = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_code,
  input  logic              dat_wr,
  input  logic [7:0]        dat_code,
  input  logic              dat_rd,
  output logic [N_SENS-1:0] rd_bits
);
  localparam int RL  = (TEMP_LEN > CFG_LEN) ? TEMP_LEN : CFG_LEN;
  localparam int CPW = $clog2(CMD_W + 1);
  localparam int PW  = $clog2(RL + 1);

  logic                clk_low;
  logic [CPW-1:0]      cmd_pos;
  logic [CMD_W-1:0]    cmd;
  logic [PW-1:0]       rd_pos;
  logic [RL-1:0]       data_word;
  logic [TEMP_LEN-1:0] temp_q [N_SENS];
  logic [CFG_LEN-1:0]  cfg_q  [N_SENS];

  wire cmd_done = (cmd_pos == CPW'(CMD_W));
  wire sel_temp = cmd_done && (cmd == CMD_RD_TEMP);
  wire sel_cfg  = cmd_done && (cmd == CMD_RD_CFG);
  wire armed    = sel_temp || sel_cfg;
  wire [PW-1:0] rd_len = sel_temp ? PW'(TEMP_LEN) : PW'(CFG_LEN);

  wire rst_cmd  = ctl_wr && (ctl_code == CTL_RST);
  wire en_rd    = dat_wr && (dat_code == DAT_EN_RD);
  wire accept   = dat_wr && clk_low && (dat_code != DAT_EN_RD);
  wire bit_in   = (dat_code == DAT_ONE);
  wire [CMD_W-1:0] cmd_next = cmd | (CMD_W'(bit_in) << cmd_pos);

  wire conv_hit = accept && !cmd_done && (cmd_pos == CPW'(CMD_W - 1)) && (cmd_next == CMD_CONV);
  wire rd_step  = !dat_wr && dat_rd && armed;
  wire rd_last  = rd_step && ((rd_pos + PW'(1)) >= rd_len);
  wire clear_all = rst_cmd || conv_hit || rd_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_low   <= 1'b0;
      cmd_pos   <= '0;
      cmd       <= '0;
      rd_pos    <= '0;
      data_word <= '0;
    end else begin
      if (ctl_wr && ctl_code == CTL_CLK_LO)      clk_low <= 1'b1;
      else if (ctl_wr && ctl_code == CTL_CLK_HI) clk_low <= 1'b0;

      if (clear_all) begin
        cmd_pos   <= '0;
        cmd       <= '0;
        rd_pos    <= '0;
        data_word <= '0;
      end else if (en_rd) begin
        rd_pos <= '0;
      end else if (accept && !cmd_done) begin
        cmd     <= cmd_next;
        cmd_pos <= cmd_pos + CPW'(1);
      end else if (accept) begin
        if (rd_pos < PW'(RL)) begin
          data_word <= data_word | (RL'(bit_in) << rd_pos);
          rd_pos    <= rd_pos + PW'(1);
        end
      end else if (rd_step) begin
        rd_pos <= rd_pos + PW'(1);
      end
    end
  end

  for (genvar i = 0; i < N_SENS; i++) begin : g_sens
    logic [RL-1:0] cur;
    logic [RL-1:0] sh;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        temp_q[i] <= TEMP_INIT;
        cfg_q[i]  <= CFG_INIT;
      end
    end

    assign cur = sel_temp ? RL'(temp_q[i]) : RL'(cfg_q[i]);
    assign sh  = cur >> rd_pos;
    assign rd_bits[i] = dat_rd && armed && (rd_pos < rd_len) && sh[0];
  end
endmodule

module quad_thermo_shifter_chk #(
  parameter int N_SENS = 4,
  parameter int CMD_W  = 8,
  parameter int RL     = 9,
  parameter int CPW    = 4,
  parameter int PW     = 4,
  parameter logic [7:0] CTL_RST   = 8'h01,
  parameter logic [7:0] DAT_EN_RD = 8'h02,
  parameter logic [CMD_W-1:0] CMD_RD_CFG  = 8'hAC,
  parameter logic [CMD_W-1:0] CMD_RD_TEMP = 8'hAA
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic [7:0]        ctl_code,
  input logic              dat_wr,
  input logic [7:0]        dat_code,
  input logic              dat_rd,
  input logic [N_SENS-1:0] rd_bits,
  input logic              clk_low,
  input logic [CPW-1:0]    cmd_pos,
  input logic [CMD_W-1:0]  cmd,
  input logic [PW-1:0]     rd_pos,
  input logic [RL-1:0]     data_word
);
  logic live;
  assign live = (cmd_pos == CPW'(CMD_W)) && (cmd == CMD_RD_TEMP || cmd == CMD_RD_CFG);

  a_r2_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_code == CTL_RST |=> cmd_pos == '0 && cmd == '0 && rd_pos == '0 && data_word == '0);

  a_r3_ignored_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr && dat_wr && !clk_low && dat_code != DAT_EN_RD
      |=> $stable(cmd_pos) && $stable(cmd) && $stable(rd_pos) && $stable(data_word));

  a_r6_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr && dat_wr && dat_code == DAT_EN_RD |=> rd_pos == '0 && $stable(cmd_pos) && $stable(cmd));

  a_r10_unarmed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd && !live |-> rd_bits == '0);

  a_r10_unarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr && !dat_wr && dat_rd && !live |=> $stable(rd_pos) && $stable(cmd_pos));

  a_r4_cmd_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pos <= CPW'(CMD_W));
endmodule

bind quad_thermo_shifter quad_thermo_shifter_chk #(
  .N_SENS(N_SENS), .CMD_W(CMD_W), .RL(RL), .CPW(CPW), .PW(PW),
  .CTL_RST(CTL_RST), .DAT_EN_RD(DAT_EN_RD),
  .CMD_RD_CFG(CMD_RD_CFG), .CMD_RD_TEMP(CMD_RD_TEMP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_code(ctl_code),
  .dat_wr(dat_wr), .dat_code(dat_code), .dat_rd(dat_rd), .rd_bits(rd_bits),
  .clk_low(clk_low), .cmd_pos(cmd_pos), .cmd(cmd), .rd_pos(rd_pos),
  .data_word(data_word)
);

// File: tb/quad_thermo_shifter_tb.sv
module quad_thermo_shifter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_code = 8'h00;
  logic       dat_wr = 1'b0;
  logic [7:0] dat_code = 8'h00;
  logic       dat_rd = 1'b0;
  logic [3:0] rd_bits;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [8:0] TEMP = 9'd44;
  localparam logic [7:0] CFG  = 8'h02;

  always #5 clk = ~clk;

  quad_thermo_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_code(ctl_code),
    .dat_wr(dat_wr), .dat_code(dat_code), .dat_rd(dat_rd), .rd_bits(rd_bits)
  );

  task automatic cyc(input logic cw, input logic [7:0] cc, input logic dw,
                     input logic [7:0] dc, input logic dr, output logic [3:0] got);
    @(negedge clk);
    ctl_wr = cw; ctl_code = cc; dat_wr = dw; dat_code = dc; dat_rd = dr;
    #2 got = rd_bits;
    @(posedge clk);
    #1 ctl_wr = 1'b0; dat_wr = 1'b0; dat_rd = 1'b0;
  endtask

  task automatic ctl(input logic [7:0] c);
    logic [3:0] g;
    cyc(1'b1, c, 1'b0, 8'h00, 1'b0, g);
  endtask

  task automatic wr(input logic [7:0] c);
    logic [3:0] g;
    cyc(1'b0, 8'h00, 1'b1, c, 1'b0, g);
  endtask

  task automatic rd(output logic [3:0] g);
    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, g);
  endtask

  task automatic send(input logic [7:0] c);
    for (int b = 0; b < 8; b++) wr(c[b] ? 8'h01 : 8'h00);
  endtask

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] exp_bit(input logic [7:0] c, input int k);
    if (c == 8'hAA && k < 9) return {4{TEMP[k]}};
    if (c == 8'hAC && k < 8) return {4{CFG[k]}};
    return 4'h0;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] g;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state, R10 unarmed reads return zero
    rd(g); check("R1 read after reset", g, 4'h0);
    rd(g); check("R10 second unarmed read", g, 4'h0);

    // R3 bits ignored while clock-low flag is clear
    send(8'hAA);
    rd(g); check("R3 command ignored with clock high", g, 4'h0);
    ctl(8'h02);
    send(8'hAA);
    rd(g); check("R3 bit0 after clock low", g, {4{TEMP[0]}});
    rd(g); check("R3 bit1 after clock low", g, {4{TEMP[1]}});
    rd(g); check("R3 bit2 after clock low", g, {4{TEMP[2]}});

    // R6 rewind mid burst, also with clock high
    ctl(8'h01);
    send(8'hAA);
    for (int k = 0; k < 4; k++) begin rd(g); check("R6 pre-rewind read", g, {4{TEMP[k]}}); end
    ctl(8'h04);
    wr(8'h02);
    for (int k = 0; k < 3; k++) begin rd(g); check("R6 post-rewind read", g, {4{TEMP[k]}}); end
    ctl(8'h02);

    // R9 data bits after a complete command shift the read position
    ctl(8'h01);
    send(8'hAA);
    wr(8'h01);
    wr(8'h00);
    for (int k = 2; k < 9; k++) begin rd(g); check("R9 shifted read", g, {4{TEMP[k]}}); end
    rd(g); check("R9 auto-clear after last bit", g, 4'h0);

    // R2 control reset mid command
    ctl(8'h01);
    for (int b = 0; b < 4; b++) wr(8'hAA >> b & 8'h01 ? 8'h01 : 8'h00);
    ctl(8'h01);
    send(8'hAC);
    for (int k = 0; k < 8; k++) begin rd(g); check("R2 config after mid-command reset", g, {4{CFG[k]}}); end
    rd(g); check("R2 config auto-clear", g, 4'h0);

    // R5 start convert clears shifter so next command is taken fresh
    send(8'hEE);
    rd(g); check("R5 start convert reads zero", g, 4'h0);
    send(8'hAA);
    for (int k = 0; k < 9; k++) begin rd(g); check("R5 temp after start convert", g, {4{TEMP[k]}}); end

    // R5 unknown command arms nothing, later bits go to the data word
    ctl(8'h01);
    send(8'h55);
    send(8'hAA);
    rd(g); check("R5 unknown command read", g, 4'h0);

    // R11 control reset wins over same-cycle data write
    ctl(8'h01);
    cyc(1'b1, 8'h01, 1'b1, 8'h01, 1'b0, g);
    send(8'hAA);
    for (int k = 0; k < 9; k++) begin rd(g); check("R11 reset beats write", g, {4{TEMP[k]}}); end

    // R4 R5 R7 R8 sweep over every command value
    for (int c = 0; c < 256; c++) begin
      ctl(8'h01);
      send(8'(c));
      for (int k = 0; k < 10; k++) begin
        rd(g);
        check($sformatf("R7 sweep cmd=%02h k=%0d", c, k), g, exp_bit(8'(c), k));
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule